// File: doc/BRIEF.md
# Universal Bus Transceiver Register

This block is a bidirectional register path between an A port and a B port. Each direction has its own active-low output enable, latch enable and direction clock. A single storage element per direction works in one of three ways. It is transparent while the latch enable is high. It holds its value while the latch enable is low and the direction clock does not rise. It captures the input on a rising edge of the direction clock while the latch enable is low.

The path is split into halves of `HALF_W` bits, two by default, and each half has its own set of controls. With `MERGED` set to 0 the halves run independently as two narrow transceivers. With `MERGED` set to 1 the controls of half 0 govern the whole width as one wide transceiver, and the controls of the other halves are ignored. Storage is clocked by a fast system clock. The direction clocks are sampled and edge-detected, so a transparent update shows up at the output one system clock later.

The block drives no high-impedance value. Each output bit comes with an enable bit, and the tri-state pad sits outside the block. While an enable bit is deasserted, the matching data bit is forced to zero.

Top module: `ubt_reg`

## Requirements
- R1: While a half's A-to-B latch enable is high, that half's `b_out` equals the `a_in` value sampled on the previous system clock edge.
- R2: While the latch enable is low and the direction clock does not go from 0 to 1, the stored A-to-B value is held. This covers the direction clock steady low, steady high and falling.
- R3: While the latch enable is low, a 0-to-1 change of the direction clock between two system clock edges captures `a_in` at the second edge. Later changes of `a_in` are not seen.
- R4: When a half's active-low output enable is 0, all of its output-enable bits are 1 and the stored data is presented. When the output enable is 1, all of its enable bits are 0 and its data bits are 0.
- R5: Storage keeps working while outputs are disabled. A value captured while disabled appears once the enable returns.
- R6: B-to-A flow behaves in the same way using `ba_oe_n`, `ba_le` and `ba_clk`, and it does not disturb the A-to-B contents.
- R7: With `MERGED`=0, the control bit of index h affects only bits [h*HALF_W +: HALF_W].
- R8: With `MERGED`=1, the controls of index 0 govern every bit in both directions, and the control bits of the other halves have no effect.
- R9: After reset, both stored words are all zeros and no direction clock edge is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the direction clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | HALF_W*NUM_HALVES | Data arriving at the A side |
| b_in | input | HALF_W*NUM_HALVES | Data arriving at the B side |
| ab_oe_n | input | NUM_HALVES | Active-low output enable per half, A to B |
| ab_le | input | NUM_HALVES | Latch enable per half, A to B |
| ab_clk | input | NUM_HALVES | Direction clock per half, A to B |
| ba_oe_n | input | NUM_HALVES | Active-low output enable per half, B to A |
| ba_le | input | NUM_HALVES | Latch enable per half, B to A |
| ba_clk | input | NUM_HALVES | Direction clock per half, B to A |
| b_out | output | HALF_W*NUM_HALVES | Data toward the B pads, zero where disabled |
| b_oe | output | HALF_W*NUM_HALVES | Per-bit drive enable for the B pads |
| a_out | output | HALF_W*NUM_HALVES | Data toward the A pads, zero where disabled |
| a_oe | output | HALF_W*NUM_HALVES | Per-bit drive enable for the A pads |

## Verification
The hardest case to reach is a capture made while the outputs are disabled. It can only be seen by enabling the outputs again without a new rising edge and without reopening the latch. The stimulus table therefore raises the direction clock while the enable is off. It then holds the clock high as the enable returns and checks for the captured value, not the latest input. Steady-high and falling direction clocks are also placed between captures, which shows that only a 0-to-1 step stores data. A second instance built with merged controls gets opposing controls on its upper half, and must follow half 0 alone.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
   // Controls for one direction of one half
   typedef struct packed {
      logic oe_n;
      logic le;
      logic dclk;
   } dir_ctrl_t;
endpackage

// File: rtl/ubt_ctrl_map.sv
module ubt_ctrl_map
   import ubt_pkg::*;
#(
   parameter int NUM_HALVES = 2,
   parameter bit MERGED     = 1'b0
) (
   input  logic [NUM_HALVES-1:0] oe_n_i,
   input  logic [NUM_HALVES-1:0] le_i,
   input  logic [NUM_HALVES-1:0] dclk_i,
   output dir_ctrl_t [NUM_HALVES-1:0] ctl_o
);
   generate
      for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
         if (MERGED) begin : g_tied
            assign ctl_o[h] = '{oe_n: oe_n_i[0], le: le_i[0], dclk: dclk_i[0]};
         end else begin : g_own
            assign ctl_o[h] = '{oe_n: oe_n_i[h], le: le_i[h], dclk: dclk_i[h]};
         end
      end
   endgenerate
endmodule

// File: rtl/ubt_store_lane.sv
module ubt_store_lane
   import ubt_pkg::*;
#(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  dir_ctrl_t    ctl_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o,
   output logic [W-1:0] oe_o
);
   logic         dclk_q;
   logic [W-1:0] store_q;
   logic         dclk_rise;

   assign dclk_rise = ctl_i.dclk & ~dclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dclk_q  <= 1'b0;
         store_q <= '0;
      end else begin
         dclk_q <= ctl_i.dclk;
         if (ctl_i.le || dclk_rise) begin
            store_q <= d_i;
         end
      end
   end

   assign oe_o = {W{~ctl_i.oe_n}};
   assign q_o  = store_q & oe_o;
endmodule

// File: rtl/ubt_reg.sv
module ubt_reg
   import ubt_pkg::*;
#(
   parameter int HALF_W     = 9,
   parameter int NUM_HALVES = 2,
   parameter bit MERGED     = 1'b0,
   localparam int TOT_W     = HALF_W * NUM_HALVES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [TOT_W-1:0]      a_in,
   input  logic [TOT_W-1:0]      b_in,
   input  logic [NUM_HALVES-1:0] ab_oe_n,
   input  logic [NUM_HALVES-1:0] ab_le,
   input  logic [NUM_HALVES-1:0] ab_clk,
   input  logic [NUM_HALVES-1:0] ba_oe_n,
   input  logic [NUM_HALVES-1:0] ba_le,
   input  logic [NUM_HALVES-1:0] ba_clk,
   output logic [TOT_W-1:0]      b_out,
   output logic [TOT_W-1:0]      b_oe,
   output logic [TOT_W-1:0]      a_out,
   output logic [TOT_W-1:0]      a_oe
);
   generate
      if (HALF_W < 1) begin : g_bad_width
         $error("ubt_reg: HALF_W must be at least 1");
      end
      if (NUM_HALVES < 1) begin : g_bad_halves
         $error("ubt_reg: NUM_HALVES must be at least 1");
      end
   endgenerate

   dir_ctrl_t [NUM_HALVES-1:0] ab_ctl;
   dir_ctrl_t [NUM_HALVES-1:0] ba_ctl;

   ubt_ctrl_map #(.NUM_HALVES(NUM_HALVES), .MERGED(MERGED)) u_ab_map (
      .oe_n_i(ab_oe_n), .le_i(ab_le), .dclk_i(ab_clk), .ctl_o(ab_ctl)
   );

   ubt_ctrl_map #(.NUM_HALVES(NUM_HALVES), .MERGED(MERGED)) u_ba_map (
      .oe_n_i(ba_oe_n), .le_i(ba_le), .dclk_i(ba_clk), .ctl_o(ba_ctl)
   );

   generate
      for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
         ubt_store_lane #(.W(HALF_W)) u_ab (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl_i (ab_ctl[h]),
            .d_i   (a_in[h*HALF_W +: HALF_W]),
            .q_o   (b_out[h*HALF_W +: HALF_W]),
            .oe_o  (b_oe[h*HALF_W +: HALF_W])
         );
         ubt_store_lane #(.W(HALF_W)) u_ba (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl_i (ba_ctl[h]),
            .d_i   (b_in[h*HALF_W +: HALF_W]),
            .q_o   (a_out[h*HALF_W +: HALF_W]),
            .oe_o  (a_oe[h*HALF_W +: HALF_W])
         );
      end
   endgenerate
endmodule

// File: rtl/ubt_chk.sv
module ubt_chk #(
   parameter int HALF_W     = 9,
   parameter int NUM_HALVES = 2,
   parameter bit MERGED     = 1'b0,
   localparam int TOT_W     = HALF_W * NUM_HALVES
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [TOT_W-1:0]      a_in,
   input logic [TOT_W-1:0]      b_in,
   input logic [NUM_HALVES-1:0] ab_oe_n,
   input logic [NUM_HALVES-1:0] ab_le,
   input logic [NUM_HALVES-1:0] ab_clk,
   input logic [NUM_HALVES-1:0] ba_oe_n,
   input logic [NUM_HALVES-1:0] ba_le,
   input logic [NUM_HALVES-1:0] ba_clk,
   input logic [TOT_W-1:0]      b_out,
   input logic [TOT_W-1:0]      b_oe,
   input logic [TOT_W-1:0]      a_out,
   input logic [TOT_W-1:0]      a_oe
);
   AST_GATED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((b_out & ~b_oe) == '0) && ((a_out & ~a_oe) == '0)); // R4

   AST_AB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      ab_le[0] |=> (ab_oe_n[0] || (b_out[HALF_W-1:0] == $past(a_in[HALF_W-1:0])))); // R1

   AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_le[0] && !ab_clk[0] && !ab_oe_n[0]) |=> (ab_oe_n[0] || $stable(b_out[HALF_W-1:0]))); // R2

   AST_BA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      ba_le[0] |=> (ba_oe_n[0] || (a_out[HALF_W-1:0] == $past(b_in[HALF_W-1:0])))); // R6

   generate
      if (MERGED) begin : g_merged
         AST_MERGED_OE: assert property (@(posedge clk) disable iff (!rst_n)
            (b_oe == {NUM_HALVES{b_oe[HALF_W-1:0]}}) && (a_oe == {NUM_HALVES{a_oe[HALF_W-1:0]}})); // R8
      end
   endgenerate
endmodule

bind ubt_reg ubt_chk #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES), .MERGED(MERGED)) u_chk (.*);

// File: tb/tb_ubt_reg.sv
`timescale 1ns/1ps
module tb_ubt_reg;
   localparam int HW = 9;
   localparam int TW = 2 * HW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [TW-1:0] a_in = '0, b_in = '0;
   logic [1:0]    ab_oe_n = 2'b00, ab_le = 2'b00, ab_clk = 2'b00;
   logic [1:0]    ba_oe_n = 2'b00, ba_le = 2'b00, ba_clk = 2'b00;
   logic [TW-1:0] b_out, b_oe, a_out, a_oe;
   logic [TW-1:0] mb_out, mb_oe, ma_out, ma_oe;
   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   ubt_reg #(.HALF_W(HW), .NUM_HALVES(2), .MERGED(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk(ab_clk),
      .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk),
      .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe));

   ubt_reg #(.HALF_W(HW), .NUM_HALVES(2), .MERGED(1'b1)) dut_m (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk(ab_clk),
      .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk),
      .b_out(mb_out), .b_oe(mb_oe), .a_out(ma_out), .a_oe(ma_oe));

   // {a1, a0, le[1:0], clk[1:0], oe_n[1:0], exp_b1, exp_b0, exp_oe[1:0]}
   localparam int NV = 10;
   localparam logic [43:0] VEC [NV] = '{
      {9'h15A, 9'h0A5, 2'b11, 2'b00, 2'b00, 9'h15A, 9'h0A5, 2'b11},
      {9'h0F0, 9'h1FF, 2'b10, 2'b00, 2'b00, 9'h0F0, 9'h0A5, 2'b11},
      {9'h00F, 9'h1FF, 2'b00, 2'b01, 2'b00, 9'h0F0, 9'h1FF, 2'b11},
      {9'h00F, 9'h033, 2'b00, 2'b11, 2'b00, 9'h00F, 9'h1FF, 2'b11},
      {9'h111, 9'h044, 2'b00, 2'b10, 2'b00, 9'h00F, 9'h1FF, 2'b11},
      {9'h111, 9'h044, 2'b00, 2'b00, 2'b01, 9'h00F, 9'h000, 2'b10},
      {9'h111, 9'h066, 2'b00, 2'b01, 2'b01, 9'h00F, 9'h000, 2'b10},
      {9'h111, 9'h077, 2'b00, 2'b01, 2'b10, 9'h000, 9'h066, 2'b01},
      {9'h1AB, 9'h077, 2'b11, 2'b01, 2'b10, 9'h000, 9'h077, 2'b01},
      {9'h000, 9'h000, 2'b00, 2'b00, 2'b00, 9'h1AB, 9'h077, 2'b11}
   };

   task automatic chk(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R9 reset state, outputs enabled
      chk("R9 b_out after reset", b_out, '0);
      chk("R9 a_out after reset", a_out, '0);
      chk("R4 b_oe enabled", b_oe, {TW{1'b1}});

      // Table walk: R1 R2 R3 R4 R5 R7
      for (int i = 0; i < NV; i++) begin
         a_in    = VEC[i][43:26];
         ab_le   = VEC[i][25:24];
         ab_clk  = VEC[i][23:22];
         ab_oe_n = VEC[i][21:20];
         tick();
         chk($sformatf("R1/R2/R3/R5/R7 vec %0d b_out", i), b_out, VEC[i][19:2]);
         chk($sformatf("R4/R7 vec %0d b_oe", i), b_oe,
             {{HW{VEC[i][1]}}, {HW{VEC[i][0]}}});
      end

      // R6: B-to-A transparent, A-to-B untouched
      b_in  = {9'h0C3, 9'h13C};
      ba_le = 2'b11;
      tick();
      chk("R6 a_out transparent", a_out, {9'h0C3, 9'h13C});
      chk("R6 b_out undisturbed", b_out, {9'h1AB, 9'h077});
      // R6: B-to-A capture on half 0 rise, half 1 held
      ba_le = 2'b00;
      tick();
      b_in   = {9'h001, 9'h1E1};
      ba_clk = 2'b01;
      tick();
      chk("R6 a_out edge capture", a_out, {9'h0C3, 9'h1E1});
      chk("R8 merged a_out follows half 0 clock", ma_out, {9'h001, 9'h1E1});
      b_in = {9'h1FF, 9'h1FF};
      tick();
      chk("R3 no capture on steady high", a_out, {9'h0C3, 9'h1E1});

      // R8: merged follows half 0, split honours half 1 separately (R7)
      a_in    = {9'h155, 9'h0AA};
      ab_le   = 2'b01;
      ab_oe_n = 2'b10;
      tick();
      chk("R8 merged b_out", mb_out, {9'h155, 9'h0AA});
      chk("R8 merged b_oe", mb_oe, {TW{1'b1}});
      chk("R7 split b_out", b_out, {9'h000, 9'h0AA});
      chk("R7 split b_oe", b_oe, {{HW{1'b0}}, {HW{1'b1}}});
      // half 1 latch open and clock rising, half 0 closed: merged holds
      ab_le   = 2'b10;
      ab_clk  = 2'b10;
      ab_oe_n = 2'b00;
      a_in    = {9'h0EE, 9'h111};
      tick();
      chk("R8 merged ignores half 1 controls", mb_out, {9'h155, 9'h0AA});
      chk("R7 split half 1 transparent", b_out, {9'h0EE, 9'h0AA});

      // R9: reset clears stored data
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      ab_le = 2'b00;
      ab_clk = 2'b00;
      tick();
      chk("R9 b_out cleared by reset", b_out, '0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule